// File: doc/BRIEF.md
# External Pin Interrupt Sense Unit

This block sits between the device pins and a parent interrupt controller. It watches one non-maskable interrupt line and sixteen general interrupt lines. Each line passes through a synchroniser, then through a detector whose trigger sense software picks. Each line has one status flag, and that flag drives a level-high request to the parent controller.

Software reaches the unit through a plain 32-bit register port with separate read and write strobes. It programs the trigger sense of each line, reads the flags and drops edge-captured flags by writing ones. A line set to low-level sense has a flag that copies the input: the flag rises while the pin is low and falls on its own when the pin returns high. That flag ignores clear writes. Edge-sensed flags stay set until software clears them. A fresh edge outranks a clear that arrives in the same cycle.

Top module: `pinIrqSense`

## Requirements
- R1: After reset, all flags, both sense registers, both request outputs and the read data are 0.
- R2: The NMI sense is bit 0 of the register at byte offset 0x08. Value 0 selects falling edge and 1 selects rising edge. The NMI flag sets only on the selected edge.
- R3: Writing 1 to bit 0 of offset 0x04 clears the NMI flag. A write there with bit 0 equal to 0 leaves the flag unchanged.
- R4: Line n has a 2-bit sense field at bits 2n+1:2n of offset 0x18. The codes are: 0 low level, 1 falling edge, 2 rising edge, 3 both edges. An edge-mode flag sets only on the edges its code selects.
- R5: In low-level sense, the flag is 1 while the synchronised input is low and returns to 0 by itself once the input is high. Clear writes have no effect on it.
- R6: In an edge mode, writing 1 to bit n of offset 0x14 clears flag n. Flags whose write bit is 0 keep their value.
- R7: If an edge is detected on a line in the same cycle that a clear write for that line is taken, the flag stays set.
- R8: A pin change reaches the flag and the request output on the third rising clock edge after the change. This latency comes from a two-stage synchroniser followed by the flag register.
- R9: The request outputs equal the flags. A read strobe latches the data for its address into the read data, which appears after the next clock edge. The NMI flag reads as bit 0 of offset 0x00 and the line flags read as bits 15:0 of offset 0x10.
- R10: Both sense registers read back the value last written to them: bit 0 at 0x08 and all 32 bits at 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| nmiPin | input | 1 | Asynchronous non-maskable interrupt pin |
| irqPins | input | 16 | Asynchronous general interrupt pins |
| regAddr | input | 8 | Register byte offset |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 32 | Registered read data |
| nmiReq | output | 1 | Level-high NMI request |
| irqReq | output | 16 | Level-high request per line |

## Verification
A sense field decoded wrongly shows up three clock edges after the pin toggles. The request then either rises on the wrong edge or misses the right one, and the bench compares the request pins at exactly that point. A bad clear priority or a bad level-mode hold shows up one edge after the clear write, on the next status read and on the request port. Wrong bit placement shows up as a neighbouring bit in the full-word status compare.

// File: rtl/pinIrqPkg.sv
package pinIrqPkg;
  localparam int unsigned IRQ_LINES = 16;
  localparam int unsigned DATA_W    = 32;

  localparam int unsigned OFS_NMI_STAT  = 'h00;
  localparam int unsigned OFS_NMI_CLR   = 'h04;
  localparam int unsigned OFS_NMI_SENSE = 'h08;
  localparam int unsigned OFS_IRQ_STAT  = 'h10;
  localparam int unsigned OFS_IRQ_CLR   = 'h14;
  localparam int unsigned OFS_IRQ_SENSE = 'h18;

  typedef enum logic [1:0] {
    SENSE_LVL_LOW = 2'd0,
    SENSE_FALL    = 2'd1,
    SENSE_RISE    = 2'd2,
    SENSE_BOTH    = 2'd3
  } senseSel_t;

  typedef struct packed {
    logic                 nmiClr;
    logic [IRQ_LINES-1:0] irqClr;
  } clrStrb_t;
endpackage

// File: rtl/pinIrqCtrl.sv
module pinIrqCtrl
  import pinIrqPkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic                   regWrEn,
  input  logic [DATA_W-1:0]      regWrData,
  input  logic                   regRdEn,
  input  logic                   nmiFlag,
  input  logic [IRQ_LINES-1:0]   irqFlag,
  output logic [DATA_W-1:0]      regRdData,
  output logic                   nmiSense,
  output logic [2*IRQ_LINES-1:0] irqSense,
  output clrStrb_t               clrStrb
);
  logic hitNmiClr, hitNmiSense, hitIrqClr, hitIrqSense;
  logic [DATA_W-1:0] rdMux;

  assign hitNmiClr   = (regAddr == ADDR_W'(OFS_NMI_CLR));
  assign hitNmiSense = (regAddr == ADDR_W'(OFS_NMI_SENSE));
  assign hitIrqClr   = (regAddr == ADDR_W'(OFS_IRQ_CLR));
  assign hitIrqSense = (regAddr == ADDR_W'(OFS_IRQ_SENSE));

  // Clear strobes toward the datapath
  always_comb begin
    clrStrb.nmiClr = regWrEn && hitNmiClr && regWrData[0];
    clrStrb.irqClr = (regWrEn && hitIrqClr) ? regWrData[IRQ_LINES-1:0] : '0;
  end

  // Sense registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiSense <= 1'b0;
      irqSense <= '0;
    end else if (regWrEn) begin
      if (hitNmiSense) nmiSense <= regWrData[0];
      if (hitIrqSense) irqSense <= regWrData[2*IRQ_LINES-1:0];
    end
  end

  // Read mux, registered on the read strobe
  always_comb begin
    unique case (regAddr)
      ADDR_W'(OFS_NMI_STAT):  rdMux = DATA_W'(nmiFlag);
      ADDR_W'(OFS_NMI_SENSE): rdMux = DATA_W'(nmiSense);
      ADDR_W'(OFS_IRQ_STAT):  rdMux = DATA_W'(irqFlag);
      ADDR_W'(OFS_IRQ_SENSE): rdMux = DATA_W'(irqSense);
      default:                rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        regRdData <= '0;
    else if (regRdEn) regRdData <= rdMux;
  end

  // R9
  rd_irq_stat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(OFS_IRQ_STAT)) |=> (regRdData == DATA_W'($past(irqFlag))));

  // R10
  rd_irq_sense_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && hitIrqSense) |=> (irqSense == $past(regWrData[2*IRQ_LINES-1:0])));
endmodule

// File: rtl/pinIrqPath.sv
module pinIrqPath
  import pinIrqPkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   nmiPin,
  input  logic [IRQ_LINES-1:0]   irqPins,
  input  logic                   nmiSense,
  input  logic [2*IRQ_LINES-1:0] irqSense,
  input  clrStrb_t               clrStrb,
  output logic                   nmiFlag,
  output logic [IRQ_LINES-1:0]   irqFlag
);
  localparam int unsigned LINES = IRQ_LINES + 1;

  logic [LINES-1:0] pinVec, lvlNow, prevQ, riseV, fallV;
  logic [SYNC_STAGES-1:0][LINES-1:0] syncQ;
  logic [IRQ_LINES-1:0] irqLvl, irqHit, edgeMode, irqNext;
  logic nmiHit;

  assign pinVec = {irqPins, nmiPin};

  // Synchroniser chain plus one history stage, idle high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
      prevQ <= '1;
    end else begin
      syncQ[0] <= pinVec;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign lvlNow = syncQ[SYNC_STAGES-1];
  assign riseV  = lvlNow & ~prevQ;
  assign fallV  = ~lvlNow & prevQ;
  assign irqLvl = lvlNow[LINES-1:1];

  assign nmiHit = nmiSense ? riseV[0] : fallV[0];

  for (genvar n = 0; n < IRQ_LINES; n++) begin : g_line
    senseSel_t mode;
    assign mode        = senseSel_t'(irqSense[2*n +: 2]);
    assign edgeMode[n] = (mode != SENSE_LVL_LOW);
    assign irqHit[n]   = (mode == SENSE_FALL) ? fallV[n+1] :
                         (mode == SENSE_RISE) ? riseV[n+1] :
                         (mode == SENSE_BOTH) ? (riseV[n+1] | fallV[n+1]) : 1'b0;
    assign irqNext[n]  = !edgeMode[n]     ? ~irqLvl[n] :
                         irqHit[n]        ? 1'b1 :
                         clrStrb.irqClr[n] ? 1'b0 : irqFlag[n];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiFlag <= 1'b0;
      irqFlag <= '0;
    end else begin
      irqFlag <= irqNext;
      if (nmiHit)              nmiFlag <= 1'b1;
      else if (clrStrb.nmiClr) nmiFlag <= 1'b0;
    end
  end

  // R3
  nmi_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrStrb.nmiClr && !nmiHit) |=> !nmiFlag);

  // R5
  level_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((irqFlag ^ ~$past(irqLvl)) & ~$past(edgeMode)) == '0);

  // R6
  edge_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((clrStrb.irqClr & edgeMode & ~irqHit) != '0)
      |=> ((irqFlag & $past(clrStrb.irqClr & edgeMode & ~irqHit)) == '0));

  // R7
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((clrStrb.irqClr & irqHit) != '0)
      |=> ((irqFlag & $past(clrStrb.irqClr & irqHit)) == $past(clrStrb.irqClr & irqHit)));
endmodule

// File: rtl/pinIrqSense.sv
module pinIrqSense
  import pinIrqPkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 nmiPin,
  input  logic [IRQ_LINES-1:0] irqPins,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic                 regRdEn,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 nmiReq,
  output logic [IRQ_LINES-1:0] irqReq
);
  logic nmiSense, nmiFlag;
  logic [2*IRQ_LINES-1:0] irqSense;
  logic [IRQ_LINES-1:0] irqFlag;
  clrStrb_t clrStrb;

  pinIrqCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .nmiFlag(nmiFlag),
    .irqFlag(irqFlag), .regRdData(regRdData), .nmiSense(nmiSense),
    .irqSense(irqSense), .clrStrb(clrStrb)
  );

  pinIrqPath #(.SYNC_STAGES(SYNC_STAGES)) i_path (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin), .irqPins(irqPins),
    .nmiSense(nmiSense), .irqSense(irqSense), .clrStrb(clrStrb),
    .nmiFlag(nmiFlag), .irqFlag(irqFlag)
  );

  assign nmiReq = nmiFlag;
  assign irqReq = irqFlag;
endmodule

// File: tb/test_pinIrqSense.sv
module test_pinIrqSense;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_NMI_STAT = 8'h00, A_NMI_CLR = 8'h04, A_NMI_SENSE = 8'h08;
  localparam logic [7:0] A_IRQ_STAT = 8'h10, A_IRQ_CLR = 8'h14, A_IRQ_SENSE = 8'h18;

  // {line[3:0], sense[1:0], firstLvl, secondLvl, expFlag, expAfterClr}
  localparam int NVEC = 10;
  localparam logic [9:0] VECS [NVEC] = '{
    {4'd0,  2'd0, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd1,  2'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd2,  2'd1, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd3,  2'd1, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'd4,  2'd2, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd5,  2'd2, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd6,  2'd3, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd7,  2'd3, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd15, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd9,  2'd1, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0, nmiPin = 1'b1;
  logic [15:0] irqPins = 16'hFFFF;
  logic [7:0] regAddr = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic nmiReq;
  logic [15:0] irqReq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinIrqSense i_pinIrqSense (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin), .irqPins(irqPins),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .nmiReq(nmiReq), .irqReq(irqReq)
  );

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);

    // R1 reset state
    checkEq("R1 nmiReq", 32'(nmiReq), 0);
    checkEq("R1 irqReq", 32'(irqReq), 0);
    checkEq("R1 rdData", regRdData, 0);
    regRead(A_NMI_STAT, rd);  checkEq("R1 nmi stat", rd, 0);
    regRead(A_IRQ_STAT, rd);  checkEq("R1 irq stat", rd, 0);
    regRead(A_NMI_SENSE, rd); checkEq("R1 nmi sense", rd, 0);
    regRead(A_IRQ_SENSE, rd); checkEq("R1 irq sense", rd, 0);

    // Table walk over lines, sense codes and pin patterns
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] idx;
      logic [1:0] sen;
      string tagA, tagC;
      idx = VECS[v][9:6];
      sen = VECS[v][5:4];
      tagA = (sen == 2'd0) ? "R5 level flag" : "R4 edge flag";
      tagC = (sen == 2'd0) ? "R5 clear ignored" : "R6 edge clear";
      regWrite(A_IRQ_SENSE, 32'(sen) << (2 * idx));
      waitCyc(4);
      regWrite(A_IRQ_CLR, 32'hFFFF);
      irqPins[idx] = VECS[v][3];
      waitCyc(4);
      irqPins[idx] = VECS[v][2];
      waitCyc(4);
      regRead(A_IRQ_STAT, rd);
      checkEq(tagA, rd, VECS[v][1] ? (32'd1 << idx) : 32'd0);
      checkEq("R9 irqReq matches", 32'(irqReq), VECS[v][1] ? (32'd1 << idx) : 32'd0);
      regWrite(A_IRQ_CLR, 32'd1 << idx);
      regRead(A_IRQ_STAT, rd);
      checkEq(tagC, rd, VECS[v][0] ? (32'd1 << idx) : 32'd0);
      irqPins[idx] = 1'b1;
      waitCyc(4);
      regWrite(A_IRQ_CLR, 32'hFFFF);
    end
    regWrite(A_IRQ_SENSE, 32'h0);
    waitCyc(4);

    // R8 latency on NMI, default falling sense (R2)
    @(negedge clk);
    nmiPin = 1'b0;
    waitCyc(2);
    checkEq("R8 before third edge", 32'(nmiReq), 0);
    waitCyc(1);
    checkEq("R8 at third edge", 32'(nmiReq), 1);
    checkEq("R2 falling sets nmi", 32'(nmiReq), 1);

    // R3 clear behaviour
    regWrite(A_NMI_CLR, 32'hFFFF_FFFE);
    checkEq("R3 bit0 zero keeps flag", 32'(nmiReq), 1);
    regWrite(A_NMI_CLR, 32'h1);
    checkEq("R3 clear nmi", 32'(nmiReq), 0);
    nmiPin = 1'b1;
    waitCyc(4);
    checkEq("R2 rising ignored in falling sense", 32'(nmiReq), 0);

    // R2 rising sense, R10 readback, R9 status read
    regWrite(A_NMI_SENSE, 32'h1);
    regRead(A_NMI_SENSE, rd);
    checkEq("R10 nmi sense readback", rd, 1);
    nmiPin = 1'b0;
    waitCyc(4);
    checkEq("R2 falling ignored in rising sense", 32'(nmiReq), 0);
    nmiPin = 1'b1;
    waitCyc(4);
    checkEq("R2 rising sets nmi", 32'(nmiReq), 1);
    regRead(A_NMI_STAT, rd);
    checkEq("R9 nmi stat read", rd, 1);
    regWrite(A_NMI_CLR, 32'h1);

    // R10 full sense register readback
    regWrite(A_IRQ_SENSE, 32'hE4A5_1B3C);
    regRead(A_IRQ_SENSE, rd);
    checkEq("R10 irq sense readback", rd, 32'hE4A5_1B3C);
    regWrite(A_IRQ_SENSE, 32'hAAAA_AAAA);
    waitCyc(4);
    regWrite(A_IRQ_CLR, 32'hFFFF);

    // R6 partial clear with all lines rising
    irqPins = 16'h0000;
    waitCyc(4);
    irqPins = 16'hFFFF;
    waitCyc(4);
    checkEq("R4 all rising set", 32'(irqReq), 32'hFFFF);
    regWrite(A_IRQ_CLR, 32'h00FF);
    regRead(A_IRQ_STAT, rd);
    checkEq("R6 only written bits clear", rd, 32'hFF00);
    regWrite(A_IRQ_CLR, 32'hFFFF);

    // R7 edge and clear in the same cycle on line 3, falling sense
    regWrite(A_IRQ_SENSE, 32'h1 << 6);
    waitCyc(4);
    irqPins[3] = 1'b0;
    waitCyc(2);
    regAddr = A_IRQ_CLR; regWrData = 32'h8; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    checkEq("R7 edge wins over clear", 32'(irqReq), 32'h8);
    regWrite(A_IRQ_CLR, 32'h8);
    checkEq("R6 later clear works", 32'(irqReq), 0);
    irqPins[3] = 1'b1;
    waitCyc(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule